// File: doc/BRIEF.md
# Serial Command Word Receiver

This block sits in a fast system clock domain and listens to a serial link driven by a host controller acting as bus master. The host lowers an active-low select, sends sixteen bits with the serial clock idling low, and raises the select again after every word. Each bit is captured on the rising edge of the serial clock, most significant bit first. All three link inputs go through multi-flop synchronisers, and the block finds edges by comparing synchronised samples, so the system clock must run at least four times faster than the serial clock.

Each completed word is split into an opcode in its top four bits and an operand in its low twelve bits. The pair is presented for one system clock together with a strobe. One opcode, the configuration opcode (value 1 by default), also copies the low eight operand bits into a persistent mode register. That register drives other logic and keeps its value until the next configuration word. A word cut short by the select rising is dropped.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, `cmd_stb_o` is 0, `cmd_op_o` and `cmd_arg_o` are 0 and `mode_o` is 0.
- R2: A frame of 16 bits sent MSB first yields `cmd_op_o` equal to the first four bits received (word bits 15..12) and `cmd_arg_o` equal to the last twelve (word bits 11..0).
- R3: Each complete frame produces exactly one strobe, and the strobe is high for one system clock only.
- R4: With the default two-stage synchronisers, the strobe is high in the fourth system clock after the clock edge following the 16th rising SCK edge at the pin, i.e. latency is SYNC_STAGES + 2 cycles.
- R5: If the select rises after fewer than 16 bits, no strobe is issued, the mode register is unchanged, and the next frame is received correctly from its first bit.
- R6: A word whose opcode equals 1 loads `mode_o` with operand bits 7..0 in the same cycle as its strobe; operand bits 11..8 are dropped.
- R7: Words with any other opcode leave `mode_o` unchanged, and `cmd_op_o`, `cmd_arg_o` and `mode_o` hold their values in every cycle without a strobe.
- R8: MOSI is sampled only at rising SCK edges; changes of MOSI while SCK is high have no effect.
- R9: SCK edges while the select is high shift nothing and do not count toward a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host, idles low |
| mosi_i | input | 1 | Serial data from the host |
| cs_n_i | input | 1 | Active-low frame select |
| cmd_stb_o | output | 1 | One-cycle pulse per complete word |
| cmd_op_o | output | 4 | Opcode of the last complete word |
| cmd_arg_o | output | 12 | Operand of the last complete word |
| mode_o | output | 8 | Mode register loaded by the configuration opcode |

## Verification
The bench sends frames cut short after ten and after fifteen bits; a receiver that did not clear its bit count on select release would strobe late or merge the remainder into the next frame, giving a wrong opcode. It toggles MOSI during the SCK high phase, which catches a design sampling on the wrong edge or on level, and pulses SCK with the select high, which catches a shifter that is not gated by the select. Configuration words with nonzero operand bits 11..8 and non-configuration words catch a mode register that takes the wrong bits or loads on every opcode, and the exact strobe cycle is compared against the synchroniser depth to catch a missing or extra pipeline stage.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam int unsigned DEF_WORD_W  = 16;
   localparam int unsigned DEF_CMD_W   = 4;
   localparam int unsigned DEF_MODE_W  = 8;
   localparam int unsigned DEF_SYNC    = 2;
   localparam logic [3:0]  DEF_CFG_OP  = 4'h1;

   // Latency from pin to strobe, in system clocks.
   function automatic int unsigned strobe_latency(input int unsigned stages);
      return stages + 2;
   endfunction
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
   parameter int unsigned    W       = 1,
   parameter int unsigned    STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_cmd_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic              cs_n_s,
   output logic              word_vld_o,
   output logic [WORD_W-1:0] word_o
);
   localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic             sck_q;
   logic             sck_rise;
   logic [CNT_W-1:0] bit_cnt;
   logic [WORD_W-1:0] shreg;

   assign sck_rise = sck_s & ~sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q      <= 1'b0;
         bit_cnt    <= '0;
         shreg      <= '0;
         word_vld_o <= 1'b0;
      end else begin
         sck_q      <= sck_s;
         word_vld_o <= 1'b0;
         if (cs_n_s) begin
            bit_cnt <= '0;
         end else if (sck_rise) begin
            shreg <= {shreg[WORD_W-2:0], mosi_s};
            if (bit_cnt == LAST) begin
               bit_cnt    <= '0;
               word_vld_o <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   assign word_o = shreg;
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode #(
   parameter int unsigned     WORD_W = 16,
   parameter int unsigned     CMD_W  = 4,
   parameter int unsigned     MODE_W = 8,
   parameter logic [CMD_W-1:0] CFG_OP = 4'h1,
   localparam int unsigned    ARG_W  = WORD_W - CMD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_vld_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              stb_o,
   output logic [CMD_W-1:0]  op_o,
   output logic [ARG_W-1:0]  arg_o,
   output logic [MODE_W-1:0] mode_o
);
   logic [CMD_W-1:0] op_w;
   logic [ARG_W-1:0] arg_w;

   assign op_w  = word_i[WORD_W-1 -: CMD_W];
   assign arg_w = word_i[ARG_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_o  <= 1'b0;
         op_o   <= '0;
         arg_o  <= '0;
         mode_o <= '0;
      end else begin
         stb_o <= word_vld_i;
         if (word_vld_i) begin
            op_o  <= op_w;
            arg_o <= arg_w;
            if (op_w == CFG_OP) mode_o <= arg_w[MODE_W-1:0];
         end
      end
   end
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
   import spi_cmd_pkg::*;
#(
   parameter int unsigned      WORD_W      = DEF_WORD_W,
   parameter int unsigned      CMD_W       = DEF_CMD_W,
   parameter int unsigned      MODE_W      = DEF_MODE_W,
   parameter int unsigned      SYNC_STAGES = DEF_SYNC,
   parameter logic [CMD_W-1:0] CFG_OP      = DEF_CFG_OP,
   localparam int unsigned     ARG_W       = WORD_W - CMD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_i,
   input  logic              mosi_i,
   input  logic              cs_n_i,
   output logic              cmd_stb_o,
   output logic [CMD_W-1:0]  cmd_op_o,
   output logic [ARG_W-1:0]  cmd_arg_o,
   output logic [MODE_W-1:0] mode_o
);
   if (CMD_W == 0 || CMD_W >= WORD_W) begin : g_bad_cmd
      $error("spi_cmd_rx: CMD_W must be between 1 and WORD_W-1");
   end
   if (MODE_W == 0 || MODE_W > ARG_W) begin : g_bad_mode
      $error("spi_cmd_rx: MODE_W must fit in the operand");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_cmd_rx: SYNC_STAGES must be at least 2");
   end

   // Index order: 2 = sck, 1 = mosi, 0 = cs_n (idles high)
   logic [2:0] raw_w;
   logic [2:0] syn_w;
   assign raw_w = {sck_i, mosi_i, cs_n_i};

   spi_cmd_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b001)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_w),
      .q_o   (syn_w)
   );

   logic              word_vld;
   logic [WORD_W-1:0] word;

   spi_cmd_framer #(
      .WORD_W (WORD_W)
   ) framer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_s      (syn_w[2]),
      .mosi_s     (syn_w[1]),
      .cs_n_s     (syn_w[0]),
      .word_vld_o (word_vld),
      .word_o     (word)
   );

   spi_cmd_decode #(
      .WORD_W (WORD_W),
      .CMD_W  (CMD_W),
      .MODE_W (MODE_W),
      .CFG_OP (CFG_OP)
   ) decode_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_vld_i (word_vld),
      .word_i     (word),
      .stb_o      (cmd_stb_o),
      .op_o       (cmd_op_o),
      .arg_o      (cmd_arg_o),
      .mode_o     (mode_o)
   );
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk #(
   parameter int unsigned      CMD_W  = 4,
   parameter int unsigned      ARG_W  = 12,
   parameter int unsigned      MODE_W = 8,
   parameter logic [CMD_W-1:0] CFG_OP = 4'h1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_stb_o,
   input logic [CMD_W-1:0]  cmd_op_o,
   input logic [ARG_W-1:0]  cmd_arg_o,
   input logic [MODE_W-1:0] mode_o
);
   // R3
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb_o |=> !cmd_stb_o);

   // R6
   mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb_o && cmd_op_o == CFG_OP) |-> (mode_o == cmd_arg_o[MODE_W-1:0]));

   // R7
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_stb_o || cmd_op_o != CFG_OP) |-> $stable(mode_o));

   // R7
   fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_stb_o |-> ($stable(cmd_op_o) && $stable(cmd_arg_o)));

   // R1
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reset_state_chk: assert (!cmd_stb_o && mode_o == '0);
      end
   end
endmodule

bind spi_cmd_rx spi_cmd_rx_chk #(
   .CMD_W  (CMD_W),
   .ARG_W  (ARG_W),
   .MODE_W (MODE_W),
   .CFG_OP (CFG_OP)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_stb_o (cmd_stb_o),
   .cmd_op_o  (cmd_op_o),
   .cmd_arg_o (cmd_arg_o),
   .mode_o    (mode_o)
);

// File: tb/spi_cmd_rx_tb_top.sv
module spi_cmd_rx_tb_top;
   localparam int HALF = 3;   // system clocks per SCK half period
   localparam int LAT  = 4;   // expected pin-to-strobe latency

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        mosi = 1'b0;
   logic        cs_n = 1'b1;
   logic        stb;
   logic [3:0]  op;
   logic [11:0] arg;
   logic [7:0]  mode;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [15:0] exp_q[$];
   int          t_q[$];
   logic [7:0]  exp_mode = 8'h00;
   logic [3:0]  exp_op = 4'h0;
   logic [11:0] exp_arg = 12'h000;

   always #10 clk = ~clk;

   spi_cmd_rx dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_i     (sck),
      .mosi_i    (mosi),
      .cs_n_i    (cs_n),
      .cmd_stb_o (stb),
      .cmd_op_o  (op),
      .cmd_arg_o (arg),
      .mode_o    (mode)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // Reference model, compared every cycle away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (stb) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5 unexpected strobe", {op, arg}, 0);
            end else begin
               logic [15:0] w;
               int t;
               w = exp_q.pop_front();
               t = t_q.pop_front();
               exp_op  = w[15:12];
               exp_arg = w[11:0];
               if (w[15:12] == 4'h1) exp_mode = w[7:0];
               chk(cyc - t == LAT, "R4 strobe latency", cyc - t, LAT);
            end
         end
         // R2 R6 R7: outputs match model every cycle
         chk(op == exp_op, "R2 opcode", op, exp_op);
         chk(arg == exp_arg, "R2 operand", arg, exp_arg);
         chk(mode == exp_mode, "R6/R7 mode", mode, exp_mode);
      end
   end

   // R3: strobe never high in two consecutive cycles
   logic stb_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (stb && stb_prev) chk(1'b0, "R3 strobe width", 2, 1);
         stb_prev <= stb;
      end
   end

   task automatic wait_clk(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // Send the first nbits of w MSB first; glitch flips MOSI while SCK is high.
   task automatic send(input logic [15:0] w, input int nbits, input bit glitch);
      @(negedge clk);
      cs_n = 1'b0;
      wait_clk(HALF);
      for (int i = 15; i > 15 - nbits; i--) begin
         mosi = w[i];
         wait_clk(HALF);
         sck = 1'b1;
         if (i == 0) begin
            exp_q.push_back(w);
            t_q.push_back(cyc);
         end
         if (glitch) begin
            wait_clk(1);
            mosi = ~w[i];
            wait_clk(HALF - 1);
         end else begin
            wait_clk(HALF);
         end
         sck = 1'b0;
      end
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(2 * HALF);
   endtask

   task automatic settle(input string req);
      wait_clk(10);
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   initial begin
      wait_clk(3);
      // R1: reset state
      chk(stb == 1'b0, "R1 strobe", stb, 0);
      chk(op == 4'h0 && arg == 12'h000, "R1 fields", {op, arg}, 0);
      chk(mode == 8'h00, "R1 mode", mode, 0);
      rst_n = 1'b1;
      wait_clk(4);

      // R2: plain command word
      send(16'h2ABC, 16, 1'b0); settle("R2 word delivered");
      // R6: configuration, upper operand bits dropped
      send(16'h10A5, 16, 1'b0); settle("R6 cfg delivered");
      send(16'h1F3C, 16, 1'b0); settle("R6 cfg upper bits");
      chk(mode == 8'h3C, "R6 mode load", mode, 8'h3C);
      // R7: other opcode leaves mode
      send(16'h3FFF, 16, 1'b0); settle("R7 other opcode");
      chk(mode == 8'h3C, "R7 mode held", mode, 8'h3C);
      // R5: partial frames dropped
      send(16'h1055, 10, 1'b0); settle("R5 partial 10");
      send(16'h1077, 15, 1'b0); settle("R5 partial 15");
      chk(mode == 8'h3C, "R5 mode unchanged", mode, 8'h3C);
      send(16'h5123, 16, 1'b0); settle("R5 next frame");
      // R9: SCK while deselected
      for (int p = 0; p < 5; p++) begin
         mosi = 1'b1;
         wait_clk(HALF); sck = 1'b1;
         wait_clk(HALF); sck = 1'b0;
      end
      settle("R9 no strobe deselected");
      send(16'h8001, 16, 1'b0); settle("R9 frame after idle clocks");
      // R8: MOSI moves during SCK high
      send(16'hC3A5, 16, 1'b1); settle("R8 glitch ignored");
      send(16'h1E5A, 16, 1'b1); settle("R8 cfg with glitch");
      // R2 boundary patterns
      send(16'h0000, 16, 1'b0); settle("R2 all zeros");
      send(16'hFFFF, 16, 1'b0); settle("R2 all ones");
      // R3: back to back frames
      send(16'h1011, 16, 1'b0);
      send(16'h7456, 16, 1'b0);
      send(16'h1000, 16, 1'b0); settle("R3 back to back");
      chk(mode == 8'h00, "R6 mode cleared", mode, 8'h00);
      report();
   end

   initial begin
      wait_clk(150000);
      chk(1'b0, "watchdog", cyc, 0);
      report();
   end
endmodule